// File: doc/BRIEF.md
# Lockable Flash Controller Register Bank

This block is the software-visible register file of a serial flash controller. It holds configuration words for memory-mapped reads and writes, a command-mode configuration, a command word, an address word, four write-data words and four read-data words. Beside them it keeps a set of protection words and a general configuration word that are only stored. A host reaches every register over a simple 32-bit register bus that uses byte offsets inside a 4 KiB window. The bank turns these registers into configuration outputs for a separate transaction sequencer and hands it a one-cycle start pulse. It then takes back the completion strobe and the bytes the sequencer has read.

The bank enforces the access rules that software depends on. Configuration words can lock themselves. One command-configuration bit freezes a fixed subset of that word. The control/status word holds a ready flag that software clears by writing one, and an execute flag that only the sequencer can clear. It also holds a software chip-select bit. Moving that bit forces a flash chip select low, or releases it, and the release is held back while a transaction is pending.

Top module: `flash_reg_bank`

## Requirements
- R1: After reset the registers read: read config (0x00) 0x0300100B, write config (0x04) 0x03000002, command config (0x08) 0x00000400, control/status (0x0C) 0x00010000, command (0x10) 0x0000000B, protection config (0x18) 0x00000400, general config (0x78) 0x0000000B. Every other decoded register reads 0.
- R2: While bit 31 of the read config (0x00), write config (0x04) or command config (0x08) register is 1, a write to that register is dropped entirely.
- R3: While command-config bit 30 is 1 and bit 31 is 0, a write to 0x08 stores the written value except for the bits under mask 0x00000403, which keep their previous values.
- R4: Control/status bit 24 (ready) becomes 1 when the sequencer reports completion. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R5: Writing control/status with bit 0 (execute) at 1 while bit 0 is 0 raises `startPulse` during that write cycle, and bit 0 then reads 1. Bit 0 stays 1 until `seqDone`, whatever is written to it. A write of 1 while bit 0 is already 1 produces no start pulse.
- R6: The software chip-select bit is control/status bit 16. On a write that changes it from 1 to 0, `csN[n]` is driven low, where n is bits 9:8 of the written value. On a write that changes it from 0 to 1, the forced select is released, unless bit 0 was already 1 or the same write sets bit 0.
- R7: While bit 0 is 1 and bit 16 is 1, `csN[n]` is low, where n is bits 9:8 of control/status. At `seqDone`, with bit 16 at 1, every select goes high, including a forced select whose release was deferred.
- R8: On `seqDone`, read-data word k (offset 0x30 + 4k) loads `seqRdData[32k+31:32k]`. Bus writes to 0x30 to 0x3C are ignored.
- R9: Reads of undecoded or misaligned offsets return 0, and writes to them change no register.
- R10: Command (0x10), address (0x14), write data (0x20 to 0x2C), protection config (0x18), protection commands (0x40 to 0x64) and general config (0x78) read back the last value written. Where a register has an output port, the port carries the same value.
- R11: While reset is asserted, every `csN` output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 12 | Byte offset within the register window |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| seqDone | input | 1 | Transaction completion from the sequencer |
| seqRdData | input | 128 | Bytes read by the sequencer, word k in bits 32k+31:32k |
| startPulse | output | 1 | One-cycle transaction start |
| csN | output | 4 | Active-low chip selects |
| rdCfgOut | output | 32 | Read configuration |
| wrCfgOut | output | 32 | Write configuration |
| cmdCfgOut | output | 32 | Command-mode configuration |
| cmdOut | output | 32 | Command word |
| addrOut | output | 32 | Address word |
| wrDataOut | output | 128 | Write-data words, word k in bits 32k+31:32k |
| genCfgOut | output | 32 | General configuration |

## Verification
The register map is exercised by writing distinctive patterns to every class of register: plain storage, undecoded holes, read-only words and self-locking words. These patterns separate a decode error from a lock or masking error. The command-configuration sequence first sets bit 30 and then writes all ones to the low bits, so a wrong mask shows up as a wrong value. It then locks the word and rewrites it, which exposes a missing lock. The control/status sequences cover several cases: execute written while idle and while busy, ready cleared with a 1 and kept with a 0, and the software chip-select bit moved in both directions, both with and without a transaction pending. Together they distinguish an immediate release of the chip select from a release deferred until completion.

// File: rtl/flash_regs_pkg.sv
package flash_regs_pkg;
  localparam int RegWidth     = 32;
  localparam int AddrWidth    = 12;
  localparam int WordBits     = AddrWidth - 2;
  localparam int NumDataWords = 4;
  localparam int NumProtCmds  = 10;
  localparam int SubIdxBits   = 4;

  // word indices inside the window
  localparam logic [WordBits-1:0] IdxRdCfg   = 10'd0;
  localparam logic [WordBits-1:0] IdxWrCfg   = 10'd1;
  localparam logic [WordBits-1:0] IdxCmdCfg  = 10'd2;
  localparam logic [WordBits-1:0] IdxCtl     = 10'd3;
  localparam logic [WordBits-1:0] IdxCmd     = 10'd4;
  localparam logic [WordBits-1:0] IdxAddr    = 10'd5;
  localparam logic [WordBits-1:0] IdxProtCfg = 10'd6;
  localparam logic [WordBits-1:0] IdxDataWr  = 10'd8;
  localparam logic [WordBits-1:0] IdxDataRd  = IdxDataWr + WordBits'(NumDataWords);
  localparam logic [WordBits-1:0] IdxProt    = 10'd16;
  localparam logic [WordBits-1:0] IdxGen     = 10'd30;

  // bit positions
  localparam int LockBit    = 31;
  localparam int SubLockBit = 30;
  localparam int ReadyBit   = 24;
  localparam int SwCsBit    = 16;
  localparam int DevLo      = 8;
  localparam int DevBits    = 2;
  localparam int ExecBit    = 0;
  localparam logic [RegWidth-1:0] SubLockMask = 32'h0000_0403;

  // reset values
  localparam logic [RegWidth-1:0] RstRdCfg   = 32'h0300_100B;
  localparam logic [RegWidth-1:0] RstWrCfg   = 32'h0300_0002;
  localparam logic [RegWidth-1:0] RstCmdCfg  = 32'h0000_0400;
  localparam logic [RegWidth-1:0] RstCtl     = 32'h0001_0000;
  localparam logic [RegWidth-1:0] RstCmd     = 32'h0000_000B;
  localparam logic [RegWidth-1:0] RstProtCfg = 32'h0000_0400;
  localparam logic [RegWidth-1:0] RstGen     = 32'h0000_000B;

  typedef struct packed {
    logic                   rdCfg;
    logic                   wrCfg;
    logic                   cmdCfg;
    logic                   ctl;
    logic                   cmd;
    logic                   addr;
    logic                   protCfg;
    logic                   gen;
    logic [NumDataWords-1:0] dataWr;
    logic [NumProtCmds-1:0]  prot;
  } regStrobe_t;

  typedef enum logic [3:0] {
    SelNone, SelRdCfg, SelWrCfg, SelCmdCfg, SelCtl, SelCmd, SelAddr,
    SelProtCfg, SelDataWr, SelDataRd, SelProt, SelGen
  } readSel_t;
endpackage

// File: rtl/flash_regs_decode.sv
module flash_regs_decode
  import flash_regs_pkg::*;
(
  input  logic                  wrEn,
  input  logic [AddrWidth-1:0]  addr,
  output regStrobe_t            strb,
  output readSel_t              rdSel,
  output logic [SubIdxBits-1:0] subIdx
);
  logic [WordBits-1:0] wordIdx;
  localparam logic [WordBits-1:0] IdxDataRdEnd = IdxDataRd + WordBits'(NumDataWords);
  localparam logic [WordBits-1:0] IdxProtEnd   = IdxProt + WordBits'(NumProtCmds);

  assign wordIdx = addr[AddrWidth-1:2];

  always_comb begin
    strb   = '0;
    rdSel  = SelNone;
    subIdx = '0;
    if (addr[1:0] == 2'b00) begin
      if (wordIdx == IdxRdCfg) begin
        rdSel = SelRdCfg;   strb.rdCfg = wrEn;
      end else if (wordIdx == IdxWrCfg) begin
        rdSel = SelWrCfg;   strb.wrCfg = wrEn;
      end else if (wordIdx == IdxCmdCfg) begin
        rdSel = SelCmdCfg;  strb.cmdCfg = wrEn;
      end else if (wordIdx == IdxCtl) begin
        rdSel = SelCtl;     strb.ctl = wrEn;
      end else if (wordIdx == IdxCmd) begin
        rdSel = SelCmd;     strb.cmd = wrEn;
      end else if (wordIdx == IdxAddr) begin
        rdSel = SelAddr;    strb.addr = wrEn;
      end else if (wordIdx == IdxProtCfg) begin
        rdSel = SelProtCfg; strb.protCfg = wrEn;
      end else if (wordIdx == IdxGen) begin
        rdSel = SelGen;     strb.gen = wrEn;
      end else if (wordIdx >= IdxDataWr && wordIdx < IdxDataRd) begin
        rdSel  = SelDataWr;
        subIdx = SubIdxBits'(wordIdx - IdxDataWr);
        strb.dataWr[subIdx] = wrEn;
      end else if (wordIdx >= IdxDataRd && wordIdx < IdxDataRdEnd) begin
        rdSel  = SelDataRd;   // read-only: no strobe
        subIdx = SubIdxBits'(wordIdx - IdxDataRd);
      end else if (wordIdx >= IdxProt && wordIdx < IdxProtEnd) begin
        rdSel  = SelProt;
        subIdx = SubIdxBits'(wordIdx - IdxProt);
        strb.prot[subIdx] = wrEn;
      end
    end
  end

  // R9: an unaligned offset never produces a write strobe
  always_comb begin
    if (addr[1:0] != 2'b00) begin
      p_unaligned_r9: assert (strb == '0);
    end
  end
endmodule

// File: rtl/flash_regs_data.sv
module flash_regs_data
  import flash_regs_pkg::*;
#(
  parameter int NumCs = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  regStrobe_t                    strb,
  input  readSel_t                      rdSel,
  input  logic [SubIdxBits-1:0]         subIdx,
  input  logic [RegWidth-1:0]           wrData,
  output logic [RegWidth-1:0]           rdData,
  input  logic                          seqDone,
  input  logic [NumDataWords*RegWidth-1:0] seqRdData,
  output logic                          startPulse,
  output logic [NumCs-1:0]              csN,
  output logic [RegWidth-1:0]           rdCfgOut,
  output logic [RegWidth-1:0]           wrCfgOut,
  output logic [RegWidth-1:0]           cmdCfgOut,
  output logic [RegWidth-1:0]           cmdOut,
  output logic [RegWidth-1:0]           addrOut,
  output logic [NumDataWords*RegWidth-1:0] wrDataOut,
  output logic [RegWidth-1:0]           genCfgOut
);
  localparam int DIdxBits = $clog2(NumDataWords);

  logic [RegWidth-1:0] rdCfgQ, wrCfgQ, cmdCfgQ, ctlQ, cmdQ, addrQ, protCfgQ, genQ;
  logic [RegWidth-1:0] dataWrQ [NumDataWords];
  logic [RegWidth-1:0] dataRdQ [NumDataWords];
  logic [RegWidth-1:0] protQ   [NumProtCmds];
  logic [RegWidth-1:0] cmdCfgNext, ctlNext;
  logic                forceQ, forceNext;
  logic [DevBits-1:0]  forceIdxQ, forceIdxNext;
  logic                swFall, swRise;

  // command-config next value with masked sub-lock
  always_comb begin
    cmdCfgNext = wrData;
    if (cmdCfgQ[SubLockBit])
      cmdCfgNext = (wrData & ~SubLockMask) | (cmdCfgQ & SubLockMask);
  end

  assign startPulse = strb.ctl && wrData[ExecBit] && !ctlQ[ExecBit];
  assign swFall     = strb.ctl && ctlQ[SwCsBit] && !wrData[SwCsBit];
  assign swRise     = strb.ctl && !ctlQ[SwCsBit] && wrData[SwCsBit];

  always_comb begin
    ctlNext = ctlQ;
    if (strb.ctl) begin
      ctlNext           = wrData;
      ctlNext[ReadyBit] = wrData[ReadyBit] ? 1'b0 : ctlQ[ReadyBit];
      ctlNext[ExecBit]  = ctlQ[ExecBit] | wrData[ExecBit];
    end
    if (seqDone) begin
      ctlNext[ReadyBit] = 1'b1;
      ctlNext[ExecBit]  = 1'b0;
    end
  end

  always_comb begin
    forceNext    = forceQ;
    forceIdxNext = forceIdxQ;
    if (swFall) begin
      forceNext    = 1'b1;
      forceIdxNext = wrData[DevLo +: DevBits];
    end else if (swRise && !(wrData[ExecBit] || ctlQ[ExecBit])) begin
      forceNext = 1'b0;
    end else if (seqDone && ctlQ[SwCsBit]) begin
      forceNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdCfgQ    <= RstRdCfg;
      wrCfgQ    <= RstWrCfg;
      cmdCfgQ   <= RstCmdCfg;
      ctlQ      <= RstCtl;
      cmdQ      <= RstCmd;
      addrQ     <= '0;
      protCfgQ  <= RstProtCfg;
      genQ      <= RstGen;
      forceQ    <= 1'b0;
      forceIdxQ <= '0;
    end else begin
      if (strb.rdCfg  && !rdCfgQ[LockBit])  rdCfgQ  <= wrData;
      if (strb.wrCfg  && !wrCfgQ[LockBit])  wrCfgQ  <= wrData;
      if (strb.cmdCfg && !cmdCfgQ[LockBit]) cmdCfgQ <= cmdCfgNext;
      if (strb.cmd)     cmdQ     <= wrData;
      if (strb.addr)    addrQ    <= wrData;
      if (strb.protCfg) protCfgQ <= wrData;
      if (strb.gen)     genQ     <= wrData;
      ctlQ      <= ctlNext;
      forceQ    <= forceNext;
      forceIdxQ <= forceIdxNext;
    end
  end

  for (genvar k = 0; k < NumDataWords; k++) begin : g_data
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataWrQ[k] <= '0;
        dataRdQ[k] <= '0;
      end else begin
        if (strb.dataWr[k]) dataWrQ[k] <= wrData;
        if (seqDone)        dataRdQ[k] <= seqRdData[k*RegWidth +: RegWidth];
      end
    end
    assign wrDataOut[k*RegWidth +: RegWidth] = dataWrQ[k];
  end

  for (genvar p = 0; p < NumProtCmds; p++) begin : g_prot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          protQ[p] <= '0;
      else if (strb.prot[p]) protQ[p] <= wrData;
    end
  end

  for (genvar c = 0; c < NumCs; c++) begin : g_cs
    assign csN[c] = !((forceQ && forceIdxQ == DevBits'(c)) ||
                      (ctlQ[ExecBit] && ctlQ[SwCsBit] &&
                       ctlQ[DevLo +: DevBits] == DevBits'(c)));
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      SelRdCfg:   rdData = rdCfgQ;
      SelWrCfg:   rdData = wrCfgQ;
      SelCmdCfg:  rdData = cmdCfgQ;
      SelCtl:     rdData = ctlQ;
      SelCmd:     rdData = cmdQ;
      SelAddr:    rdData = addrQ;
      SelProtCfg: rdData = protCfgQ;
      SelGen:     rdData = genQ;
      SelDataWr:  rdData = dataWrQ[subIdx[DIdxBits-1:0]];
      SelDataRd:  rdData = dataRdQ[subIdx[DIdxBits-1:0]];
      SelProt:    rdData = protQ[subIdx];
      default:    rdData = '0;
    endcase
  end

  assign rdCfgOut  = rdCfgQ;
  assign wrCfgOut  = wrCfgQ;
  assign cmdCfgOut = cmdCfgQ;
  assign cmdOut    = cmdQ;
  assign addrOut   = addrQ;
  assign genCfgOut = genQ;

  // R2: a locked read config survives a write
  p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdCfg && rdCfgQ[LockBit]) |=> $stable(rdCfgQ));
  // R3: masked bits survive a write while the sub-lock is set
  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmdCfg && cmdCfgQ[SubLockBit]) |=>
      ((cmdCfgQ & SubLockMask) == ($past(cmdCfgQ) & SubLockMask)));
  // R4: writing one to ready clears it when no completion coincides
  p_ready_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ctl && wrData[ReadyBit] && !seqDone) |=> !ctlQ[ReadyBit]);
  // R5: execute stays set until completion
  p_exec_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctlQ[ExecBit] && !seqDone) |=> ctlQ[ExecBit]);
  // R5: a start leaves the bank busy
  p_start_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !seqDone) |=> ctlQ[ExecBit]);
  // R8: read data changes only on completion
  p_rd_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    !seqDone |=> $stable(dataRdQ[0]));
  // R11: selects are high while reset is applied
  always_comb begin
    if (!rstN) begin
      p_reset_cs_r11: assert (&csN);
    end
  end
endmodule

// File: rtl/flash_reg_bank.sv
module flash_reg_bank
  import flash_regs_pkg::*;
#(
  parameter int NumCs = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             busWrEn,
  input  logic [AddrWidth-1:0]             busAddr,
  input  logic [RegWidth-1:0]              busWrData,
  output logic [RegWidth-1:0]              busRdData,
  input  logic                             seqDone,
  input  logic [NumDataWords*RegWidth-1:0] seqRdData,
  output logic                             startPulse,
  output logic [NumCs-1:0]                 csN,
  output logic [RegWidth-1:0]              rdCfgOut,
  output logic [RegWidth-1:0]              wrCfgOut,
  output logic [RegWidth-1:0]              cmdCfgOut,
  output logic [RegWidth-1:0]              cmdOut,
  output logic [RegWidth-1:0]              addrOut,
  output logic [NumDataWords*RegWidth-1:0] wrDataOut,
  output logic [RegWidth-1:0]              genCfgOut
);
  regStrobe_t            strb;
  readSel_t              rdSel;
  logic [SubIdxBits-1:0] subIdx;

  flash_regs_decode i_decode (
    .wrEn  (busWrEn),
    .addr  (busAddr),
    .strb  (strb),
    .rdSel (rdSel),
    .subIdx(subIdx)
  );

  flash_regs_data #(.NumCs(NumCs)) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rdSel     (rdSel),
    .subIdx    (subIdx),
    .wrData    (busWrData),
    .rdData    (busRdData),
    .seqDone   (seqDone),
    .seqRdData (seqRdData),
    .startPulse(startPulse),
    .csN       (csN),
    .rdCfgOut  (rdCfgOut),
    .wrCfgOut  (wrCfgOut),
    .cmdCfgOut (cmdCfgOut),
    .cmdOut    (cmdOut),
    .addrOut   (addrOut),
    .wrDataOut (wrDataOut),
    .genCfgOut (genCfgOut)
  );
endmodule

// File: tb/test_flash_reg_bank.sv
`timescale 1ns/1ps
module test_flash_reg_bank;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWrEn = 1'b0;
  logic [11:0]  busAddr = '0;
  logic [31:0]  busWrData = '0;
  logic [31:0]  busRdData;
  logic         seqDone = 1'b0;
  logic [127:0] seqRdData = '0;
  logic         startPulse;
  logic [3:0]   csN;
  logic [31:0]  rdCfgOut, wrCfgOut, cmdCfgOut, cmdOut, addrOut, genCfgOut;
  logic [127:0] wrDataOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic sawStart;
  logic [31:0] v;

  always #5 clk = ~clk;

  flash_reg_bank i_flash_reg_bank (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .seqDone(seqDone),
    .seqRdData(seqRdData), .startPulse(startPulse), .csN(csN),
    .rdCfgOut(rdCfgOut), .wrCfgOut(wrCfgOut), .cmdCfgOut(cmdCfgOut),
    .cmdOut(cmdOut), .addrOut(addrOut), .wrDataOut(wrDataOut),
    .genCfgOut(genCfgOut)
  );

  localparam int NumVec = 18;
  localparam logic [11:0] VecAddr [NumVec] = '{
    12'h010, 12'h014, 12'h020, 12'h02C, 12'h040, 12'h064, 12'h078, 12'h01C, 12'h07C,
    12'h030, 12'h000, 12'h000, 12'h000, 12'h008, 12'h008, 12'h008, 12'h008, 12'h004};
  localparam logic [31:0] VecData [NumVec] = '{
    32'hA5A5_1234, 32'h00FF_0102, 32'h1111_2222, 32'hDEAD_BEEF, 32'h0000_0077,
    32'h1234_5678, 32'hCAFE_0001, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF,
    32'h0000_2233, 32'h8000_0044, 32'h0000_0055, 32'h4000_0000, 32'h4000_0FFF,
    32'h8000_0403, 32'h0000_0000, 32'h0000_1234};
  localparam logic [31:0] VecExp [NumVec] = '{
    32'hA5A5_1234, 32'h00FF_0102, 32'h1111_2222, 32'hDEAD_BEEF, 32'h0000_0077,
    32'h1234_5678, 32'hCAFE_0001, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
    32'h0000_2233, 32'h8000_0044, 32'h8000_0044, 32'h4000_0000, 32'h4000_0BFC,
    32'h8000_0000, 32'h8000_0000, 32'h0000_1234};
  localparam int VecReq [NumVec] = '{10, 10, 10, 10, 10, 10, 10, 9, 9, 8, 2, 2, 2, 3, 3, 3, 2, 10};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    #1 sawStart = startPulse;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic finishSeq(input logic [127:0] data);
    @(negedge clk);
    seqDone = 1'b1; seqRdData = data;
    @(negedge clk);
    seqDone = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11: selects high during reset
    #12;
    check("R11", {28'd0, csN}, 32'hF);
    @(negedge clk); rstN = 1'b1;

    // R1: reset values
    rd(12'h000, v); check("R1", v, 32'h0300_100B);
    rd(12'h004, v); check("R1", v, 32'h0300_0002);
    rd(12'h008, v); check("R1", v, 32'h0000_0400);
    rd(12'h00C, v); check("R1", v, 32'h0001_0000);
    rd(12'h010, v); check("R1", v, 32'h0000_000B);
    rd(12'h018, v); check("R1", v, 32'h0000_0400);
    rd(12'h078, v); check("R1", v, 32'h0000_000B);
    rd(12'h024, v); check("R1", v, 32'h0);
    rd(12'h034, v); check("R1", v, 32'h0);
    rd(12'h050, v); check("R1", v, 32'h0);

    // table walk (R2 R3 R8 R9 R10)
    for (int i = 0; i < NumVec; i++) begin
      wr(VecAddr[i], VecData[i]);
      rd(VecAddr[i], v);
      check($sformatf("R%0d vec %0d", VecReq[i], i), v, VecExp[i]);
    end
    check("R10 cmd port", cmdOut, 32'hA5A5_1234);
    check("R10 addr port", addrOut, 32'h00FF_0102);
    check("R10 data port", wrDataOut[127:96], 32'hDEAD_BEEF);
    check("R10 gen port", genCfgOut, 32'hCAFE_0001);
    check("R2 rd cfg port", rdCfgOut, 32'h8000_0044);
    check("R3 cmd cfg port", cmdCfgOut, 32'h8000_0000);
    rd(12'h015, v); check("R9 misaligned", v, 32'h0);
    wr(12'h011, 32'h5555_5555);
    check("R9 misaligned write", cmdOut, 32'hA5A5_1234);

    // R2: write config locks too
    wr(12'h004, 32'h8000_0000);
    wr(12'h004, 32'h0000_0005);
    check("R2 wr cfg", wrCfgOut, 32'h8000_0000);

    // R5 R7: transaction on device 1 with hardware chip select
    wr(12'h00C, 32'h0001_0101);
    check("R5 start", {31'd0, sawStart}, 32'h1);
    check("R7 cs busy", {28'd0, csN}, 32'hD);
    wr(12'h00C, 32'h0001_0100);
    rd(12'h00C, v); check("R5 exec sticky", {31'd0, v[0]}, 32'h1);
    wr(12'h00C, 32'h0001_0101);
    check("R5 no restart", {31'd0, sawStart}, 32'h0);
    finishSeq({32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111});
    rd(12'h00C, v); check("R4 R5 done", v, 32'h0101_0101 & 32'hFFFF_FFFE);
    check("R7 cs released", {28'd0, csN}, 32'hF);
    rd(12'h030, v); check("R8 word0", v, 32'h1111_1111);
    rd(12'h03C, v); check("R8 word3", v, 32'h4444_4444);
    wr(12'h030, 32'h0);
    rd(12'h030, v); check("R8 read only", v, 32'h1111_1111);

    // R4: write-one-to-clear ready
    wr(12'h00C, 32'h0001_0100);
    rd(12'h00C, v); check("R4 keep", {31'd0, v[24]}, 32'h1);
    wr(12'h00C, 32'h0101_0100);
    rd(12'h00C, v); check("R4 clear", {31'd0, v[24]}, 32'h0);

    // R6: force device 2, then release while starting a transaction
    wr(12'h00C, 32'h0000_0200);
    check("R6 force", {28'd0, csN}, 32'hB);
    wr(12'h00C, 32'h0001_0201);
    check("R6 deferred", {28'd0, csN}, 32'hB);
    finishSeq('0);
    check("R7 deferred release", {28'd0, csN}, 32'hF);

    // R6: force device 0, then plain release
    wr(12'h00C, 32'h0000_0000);
    check("R6 force dev0", {28'd0, csN}, 32'hE);
    wr(12'h00C, 32'h0001_0000);
    check("R6 release", {28'd0, csN}, 32'hF);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule